// File: doc/BRIEF.md
# Inter-processor message queue

This block carries 32-bit messages in one direction between two processors. The sending processor pushes a word by writing the message-in register. The receiving processor pops the oldest word by reading the message-out register. It can also peek at the oldest word through a look-ahead register, and that read leaves the queue unchanged. Both processors see one shared status word. It holds the flags, the message count and the raw read and write pointers, so software can track the queue without side effects.

The sender can lock the queue. While it is locked, no further word is taken in until the sender clears the lock, which it does after the receiver acknowledges. A programmable threshold drives an almost-full flag. Two pending interrupts are provided: one tells the receiver that a message has arrived, and one tells the sender that space has opened up after the queue was full. Each interrupt stays raised until its clear bit is written in the control register.

Access is through a single-cycle register port. The word address selects the register: 0 message-in, 1 message-out, 2 status, 3 control, 4 look-ahead. Read data is combinational from the current state, and a pop takes effect at the clock edge that ends the access.

Top module: `ipc_msg_queue`

## Requirements
- R1: After reset, status reads 0x0000_0008 (only empty set), control reads 0x00F0_0000 (threshold 15, unlocked), and both interrupts are low.
- R2: Words written to address 0 are returned by address-1 reads in the same order. The status word has this layout: bit 0 locked, bit 1 almost full, bit 2 full, bit 3 empty, bits 8:4 count, bits 19:16 write pointer, bits 23:20 read pointer. Each push adds 1 to the count and the write pointer; each pop subtracts 1 from the count and adds 1 to the read pointer.
- R3: At most 15 words are held. Full is set at a count of 15, and a write made while full is dropped without changing the count or the stored data.
- R4: Almost full (status bit 1) is set exactly when the count is greater than or equal to the threshold in control bits 23:20.
- R5: Writing control bit 17 as 1 sets status bit 0 and makes message-in writes be dropped. Writing it as 0 accepts writes again.
- R6: Writing control bit 16 as 1 empties the queue in one cycle: count and both pointers become 0 and empty is set. The bit reads back as 0.
- R7: Reading address 1 while the queue is empty returns 0 and does not move the read pointer.
- R8: Reading address 4 returns the oldest word and does not pop it.
- R9: The message-ready interrupt rises after an accepted write and stays high until control bit 0 is written as 1.
- R10: The space interrupt rises after a pop taken at a count of 15 and stays high until control bit 1 is written as 1.
- R11: Both pointers wrap from 15 to 0 and keep the order of the data.
- R12: Control bits 0, 1 and 16 are pulses. They always read back as 0, and control readback shows only the lock bit and the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word address of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current access |
| irq_msg_ready | output | 1 | Message-ready interrupt to the receiver |
| irq_space_avail | output | 1 | Space-available interrupt to the sender |

## Verification
The bench builds the block with its default depth of 16 and 32-bit words. With those values the fixed status fields line up exactly with the pointers and the count. A run of 15 pushes reaches the full boundary, and the write after it tests the dropped write. With the default depth, one more push after a single pop carries the write pointer across the 15-to-0 wrap, and the drain that follows checks the order of the data across that wrap. A lowered threshold of 4 shows the almost-full flag switching on at a count of 4 and not at 3.

// File: rtl/ipc_msg_queue.sv
module ipc_msg_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [31:0]   rsp_rdata,
  output logic          irq_msg_ready,
  output logic          irq_space_avail
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;
  localparam int CAP = DEPTH - 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          lock;
  logic [3:0]    thresh;

  wire is_empty = (cnt == '0);
  wire is_full  = (cnt == CW'(CAP));
  wire is_afull = (cnt >= CW'(thresh));

  wire wr_acc = req_valid & req_write;
  wire rd_acc = req_valid & ~req_write;
  wire push   = wr_acc & (req_addr == 3'd0) & ~lock & ~is_full;
  wire pop    = rd_acc & (req_addr == 3'd1) & ~is_empty;
  wire ctl_wr = wr_acc & (req_addr == 3'd3);
  wire flush  = ctl_wr & req_wdata[16];

  wire [31:0] status = {8'h00, 4'(rp), 4'(wp), 7'h00, 5'(cnt),
                        is_empty, is_full, is_afull, lock};
  wire [31:0] head   = is_empty ? 32'h0 : 32'(mem[rp]);

  always_comb begin
    rsp_rdata = '0;
    if (rd_acc) begin
      case (req_addr)
        3'd1:    rsp_rdata = head;
        3'd2:    rsp_rdata = status;
        3'd3:    rsp_rdata = {8'h00, thresh, 2'b00, lock, 17'h0};
        3'd4:    rsp_rdata = head;
        default: rsp_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      lock <= 1'b0; thresh <= 4'(CAP);
      irq_msg_ready <= 1'b0; irq_space_avail <= 1'b0;
    end else begin
      if (flush) begin
        wp <= '0; rp <= '0; cnt <= '0;
      end else begin
        if (push) begin
          wp  <= wp + 1'b1;
          cnt <= cnt + 1'b1;
        end
        if (pop) begin
          rp  <= rp + 1'b1;
          cnt <= cnt - 1'b1;
        end
      end
      if (ctl_wr) begin
        lock   <= req_wdata[17];
        thresh <= req_wdata[23:20];
        if (req_wdata[0]) irq_msg_ready   <= 1'b0;
        if (req_wdata[1]) irq_space_avail <= 1'b0;
      end
      if (push)           irq_msg_ready   <= 1'b1;
      if (pop && is_full) irq_space_avail <= 1'b1;
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CAP));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == 3'd0 && is_full) |=> cnt == $past(cnt));
  p_locked_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == 3'd0 && lock) |=> cnt == $past(cnt));
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt == '0 && wp == '0 && rp == '0));
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_addr == 3'd1 && is_empty) |=> rp == $past(rp));
  p_peek_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_addr == 3'd4) |=> (rp == $past(rp) && cnt == $past(cnt)));
  p_msg_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> irq_msg_ready);
  p_space_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && is_full) |=> irq_space_avail);
endmodule

// File: tb/tb_ipc_msg_queue.sv
module tb_ipc_msg_queue;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        irq_msg_ready, irq_space_avail;
  int          n_checks = 0, n_fail = 0;
  logic        done = 1'b0;

  ipc_msg_queue dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 d = rsp_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd2, v); check("R1 status", v, 32'h0000_0008);
    rd(3'd3, v); check("R1 control", v, 32'h00F0_0000);
    check("R1 irqs", {30'h0, irq_msg_ready, irq_space_avail}, 32'h0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    wr(3'd0, 32'hA1); wr(3'd0, 32'hB2); wr(3'd0, 32'hC3);
    rd(3'd2, v); check("R2 status after 3 pushes", v, 32'h0003_0030);
    check("R9 msg irq set", {31'h0, irq_msg_ready}, 32'h1);
    rd(3'd4, v); check("R8 peek head", v, 32'hA1);
    rd(3'd4, v); check("R8 peek again", v, 32'hA1);
    rd(3'd2, v); check("R8 peek no pop", v, 32'h0003_0030);
    rd(3'd1, v); check("R2 pop 1", v, 32'hA1);
    rd(3'd1, v); check("R2 pop 2", v, 32'hB2);
    rd(3'd1, v); check("R2 pop 3", v, 32'hC3);
    rd(3'd2, v); check("R2 status drained", v, 32'h0033_0008);
    check("R9 msg irq held", {31'h0, irq_msg_ready}, 32'h1);
    wr(3'd3, 32'h00F0_0001);
    check("R9 msg irq cleared", {31'h0, irq_msg_ready}, 32'h0);
  endtask

  task automatic t_empty_read();
    logic [31:0] v;
    rd(3'd1, v); check("R7 empty read data", v, 32'h0);
    rd(3'd2, v); check("R7 pointer held", v, 32'h0033_0008);
  endtask

  task automatic t_afull_flush();
    logic [31:0] v;
    wr(3'd3, 32'h0040_0000);
    for (int i = 0; i < 3; i++) wr(3'd0, 32'h10 + i);
    rd(3'd2, v); check("R4 below threshold", v, 32'h0036_0030);
    wr(3'd0, 32'h13);
    rd(3'd2, v); check("R4 at threshold", v, 32'h0037_0042);
    wr(3'd3, 32'h0041_0000);
    rd(3'd2, v); check("R6 flushed", v, 32'h0000_0008);
    rd(3'd3, v); check("R12 pulses read 0", v, 32'h0040_0000);
    wr(3'd3, 32'h00F0_0001);
  endtask

  task automatic t_full_wrap();
    logic [31:0] v;
    for (int i = 0; i < 15; i++) wr(3'd0, 32'd100 + i);
    rd(3'd2, v); check("R3 full status", v, 32'h000F_00F6);
    wr(3'd0, 32'hDEAD);
    rd(3'd2, v); check("R3 write when full dropped", v, 32'h000F_00F6);
    check("R10 no space irq yet", {31'h0, irq_space_avail}, 32'h0);
    rd(3'd1, v); check("R2 pop first", v, 32'd100);
    check("R10 space irq set", {31'h0, irq_space_avail}, 32'h1);
    rd(3'd2, v); check("R3 after one pop", v, 32'h001F_00E0);
    wr(3'd0, 32'd200);
    rd(3'd2, v); check("R11 write pointer wrapped", v, 32'h0010_00F6);
    for (int i = 1; i < 15; i++) begin
      rd(3'd1, v); check("R11 order across wrap", v, 32'd100 + i);
    end
    rd(3'd1, v); check("R11 wrapped entry", v, 32'd200);
    rd(3'd2, v); check("R11 read pointer wrapped", v, 32'h0000_0008);
    check("R10 space irq held", {31'h0, irq_space_avail}, 32'h1);
    wr(3'd3, 32'h00F0_0002);
    check("R10 space irq cleared", {31'h0, irq_space_avail}, 32'h0);
    check("R10 msg irq untouched", {31'h0, irq_msg_ready}, 32'h1);
    wr(3'd3, 32'h00F0_0001);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(3'd3, 32'h00F2_0000);
    rd(3'd2, v); check("R5 locked flag", v, 32'h0000_0009);
    rd(3'd3, v); check("R12 control readback", v, 32'h00F2_0000);
    wr(3'd0, 32'h55);
    rd(3'd2, v); check("R5 write dropped", v, 32'h0000_0009);
    check("R5 no msg irq", {31'h0, irq_msg_ready}, 32'h0);
    wr(3'd3, 32'h00F0_0000);
    wr(3'd0, 32'h66);
    rd(3'd1, v); check("R5 unlocked write", v, 32'h66);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_order();
    t_empty_read();
    t_afull_flush();
    t_full_wrap();
    t_lock();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule